// File: doc/BRIEF.md
# Transmit Task Handoff Controller

This block sits between a host microcontroller bus and the transmit side of a packet modem. The host first loads a small block buffer with payload bytes. It then writes a command byte. The command byte names a task and picks how the downstream checksum generators are preset. When a transmit task is accepted, the block marks its buffer busy and waits until the downstream interleave FIFO reports enough room for the whole block. It then copies the bytes out, one per clock, oldest first.

As soon as the last byte has left, the buffer is released. The buffer-free flag rises, an interrupt flag is set, and an active-low interrupt pin is pulled low if interrupts are enabled. The host can therefore stage the next block while the previous one is still being modulated downstream. A reset task aborts any pending copy and empties the buffer. Illegal accesses made while the buffer is busy are dropped and leave a sticky error flag.

The host bus has four byte addresses: 0 is the data buffer, 1 is the command register, 2 is the status register and 3 is the mode register. Reads return their data one clock after the read strobe.

Top module: `txhand_ctrl`

## Requirements
- R1: After rst_n low, status reads 0x01, irq_n is high, push_vld is low and crc_zero is 0. Status bit 0 is buffer-free, bit 1 is interrupt and bit 2 is error.
- R2: A write to address 0 while buffer-free is 1 appends a byte to the block. The first byte written is the first byte copied out. Writes beyond DEPTH bytes (default 8) are dropped.
- R3: The task code is command bits [2:0]. Code 000 is null and has no effect. Code 111 is reset. Any other code is a transmit task. An accepted transmit task clears status bit 0 at the write clock edge.
- R4: A copy starts only once fifo_room is at least the block length. push_vld is then high for exactly as many cycles as the block holds bytes.
- R5: After the last byte is copied, status bits 0 and 1 are both set, no later than n+2 cycles after the command edge. An empty block completes with no push.
- R6: irq_n is low exactly when status bit 1 is 1 and mode bit 0 is 1.
- R7: A status read returns the flags and clears bit 1. Bit 0 is not changed by the read.
- R8: A reset task (code 111) abandons any pending copy and empties the buffer. It sets bit 0 to 1 and bit 1 to 0, and no byte from the abandoned block is pushed afterwards.
- R9: While bit 0 is 0, a data-address access or a transmit task is ignored and sets the sticky error bit 2. Only rst_n clears bit 2.
- R10: Command bit 5 of an accepted transmit task is latched onto crc_zero. A value of 1 presets the checksums to all zeros; a value of 0 presets them to all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | 0 data, 1 command, 2 status, 3 mode |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read data, valid the cycle after host_rd |
| fifo_room | input | ROOM_W | Free entries in the interleave FIFO |
| push_vld | output | 1 | Byte push into the interleave FIFO |
| push_byte | output | 8 | Byte being pushed |
| crc_zero | output | 1 | Checksum preset select of the current task |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A transmit command changes the buffer-free flag at its own clock edge. The copy starts one edge later, and the flags rise one edge after the final push, so an n-byte block with room is complete by the command edge plus n+2. Register reads are registered, so the bench samples host_rdata on the falling edge after the read strobe. The bench waits n+4 cycles before checking completion. While a copy is stalled for lack of room, it re-reads status and counts pushes to show that nothing moves.

// File: rtl/txh_pkg.sv
// Shared constants and types for the transmit task handoff controller.
// Assumes a byte-wide host bus with a two-bit address.
package txh_pkg;
    localparam logic [1:0] ADR_DATA = 2'd0;
    localparam logic [1:0] ADR_CMD  = 2'd1;
    localparam logic [1:0] ADR_STAT = 2'd2;
    localparam logic [1:0] ADR_MODE = 2'd3;

    localparam logic [2:0] TASK_NULL  = 3'b000;
    localparam logic [2:0] TASK_RESET = 3'b111;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_MOVE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/txh_blkbuf.sv
// Block buffer: holds up to DEPTH host bytes in write order and exposes one
// read port indexed by the sequencer. Assumes DEPTH is a power of two.
module txh_blkbuf #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_byte,
    input  logic             clear,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic [7:0]       rd_byte
);
    logic [7:0] slot [DEPTH];
    logic       room_left;

    assign room_left = (count < CNT_W'(DEPTH));

    // Fill level: grows on accepted writes, drops to zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (wr_en && room_left) begin
            count <= count + CNT_W'(1);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Each slot captures the byte written while it is the next free one.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[g] <= 8'h00;
            end else if (wr_en && !clear && count == CNT_W'(g)) begin
                slot[g] <= wr_byte;
            end
        end
    end

    assign rd_byte = slot[rd_ptr];
endmodule

// File: rtl/txh_seq.sv
// Transfer sequencer: after a start, waits for room for the whole block, then
// pushes one byte per cycle and signals done. Abort returns it to idle.
module txh_seq
    import txh_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ROOM_W = 5,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CMP_W = (ROOM_W > CNT_W) ? ROOM_W : CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [CNT_W-1:0]  count,
    input  logic [ROOM_W-1:0] room,
    output logic              push,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic              done
);
    seq_state_t st;
    logic       fits;
    logic       empty_blk;
    logic       last;

    assign fits      = CMP_W'(room) >= CMP_W'(count);
    assign empty_blk = (count == '0);
    assign last      = (CNT_W'(rd_ptr) == count - CNT_W'(1));

    // Push and completion outputs derived from the current state.
    always_comb begin
        push = (st == SQ_MOVE) && !abort;
        done = !abort && (((st == SQ_WAIT) && empty_blk) ||
                          ((st == SQ_MOVE) && last));
    end

    // State and read pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= SQ_IDLE;
            rd_ptr <= '0;
        end else if (abort) begin
            st     <= SQ_IDLE;
            rd_ptr <= '0;
        end else begin
            unique case (st)
                SQ_IDLE: if (start) st <= SQ_WAIT;
                SQ_WAIT: begin
                    if (empty_blk) begin
                        st <= SQ_IDLE;
                    end else if (fits) begin
                        st     <= SQ_MOVE;
                        rd_ptr <= '0;
                    end
                end
                SQ_MOVE: begin
                    if (last) begin
                        st     <= SQ_IDLE;
                        rd_ptr <= '0;
                    end else begin
                        rd_ptr <= rd_ptr + PTR_W'(1);
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/txh_regs.sv
// Host registers: decodes bus accesses, holds buffer-free, interrupt, error,
// mode and checksum-select state, and returns registered read data.
// Assumes host_wr and host_rd are never high together.
module txh_regs
    import txh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [1:0] host_addr,
    input  logic [7:0] host_wdata,
    input  logic       done,
    output logic       start_tx,
    output logic       soft_rst,
    output logic       buf_wr,
    output logic       bfree,
    output logic       irq,
    output logic       err,
    output logic       irq_en,
    output logic       crc_zero,
    output logic [7:0] host_rdata
);
    logic       wr_cmd;
    logic       is_tx;
    logic       data_acc;
    logic       bad;
    logic       stat_rd;
    logic [7:0] last_cmd;

    // Bus decode into task requests and buffer writes.
    always_comb begin
        wr_cmd   = host_wr && (host_addr == ADR_CMD);
        soft_rst = wr_cmd && (host_wdata[2:0] == TASK_RESET);
        is_tx    = wr_cmd && (host_wdata[2:0] != TASK_NULL) &&
                   (host_wdata[2:0] != TASK_RESET);
        data_acc = (host_wr || host_rd) && (host_addr == ADR_DATA);
        start_tx = is_tx && bfree;
        buf_wr   = host_wr && (host_addr == ADR_DATA) && bfree;
        bad      = (is_tx || data_acc) && !bfree;
        stat_rd  = host_rd && (host_addr == ADR_STAT);
    end

    // Buffer-free flag: cleared by an accepted task, set by done or reset task.
    always_ff @(posedge clk) begin
        if (!rst_n)        bfree <= 1'b1;
        else if (soft_rst) bfree <= 1'b1;
        else if (start_tx) bfree <= 1'b0;
        else if (done)     bfree <= 1'b1;
    end

    // Interrupt flag: set on done, cleared by a status read or a reset task.
    always_ff @(posedge clk) begin
        if (!rst_n)        irq <= 1'b0;
        else if (soft_rst) irq <= 1'b0;
        else if (done)     irq <= 1'b1;
        else if (stat_rd)  irq <= 1'b0;
    end

    // Sticky error flag for accesses made while the buffer is busy.
    always_ff @(posedge clk) begin
        if (!rst_n)   err <= 1'b0;
        else if (bad) err <= 1'b1;
    end

    // Mode, checksum select and command echo registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en   <= 1'b0;
            crc_zero <= 1'b0;
            last_cmd <= 8'h00;
        end else begin
            if (host_wr && host_addr == ADR_MODE) irq_en <= host_wdata[0];
            if (start_tx) crc_zero <= host_wdata[5];
            if (wr_cmd)   last_cmd <= host_wdata;
        end
    end

    // Registered read data, valid one cycle after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= 8'h00;
        end else if (host_rd) begin
            unique case (host_addr)
                ADR_STAT: host_rdata <= {5'b0, err, irq, bfree};
                ADR_MODE: host_rdata <= {7'b0, irq_en};
                ADR_CMD:  host_rdata <= last_cmd;
                default:  host_rdata <= 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/txhand_ctrl.sv
// Top level of the transmit task handoff controller: joins the register
// file, block buffer and transfer sequencer, and drives the interrupt pin.
// Assumes fifo_room is a registered free-space count from the interleave FIFO.
module txhand_ctrl #(
    parameter int DEPTH  = 8,
    parameter int ROOM_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [1:0]        host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic [ROOM_W-1:0] fifo_room,
    output logic              push_vld,
    output logic [7:0]        push_byte,
    output logic              crc_zero,
    output logic              irq_n
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = $clog2(DEPTH);

    logic             start_tx;
    logic             soft_rst;
    logic             buf_wr;
    logic             bfree;
    logic             irq;
    logic             err;
    logic             irq_en;
    logic             done;
    logic [CNT_W-1:0] count;
    logic [PTR_W-1:0] rd_ptr;

    txh_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .done      (done),
        .start_tx  (start_tx),
        .soft_rst  (soft_rst),
        .buf_wr    (buf_wr),
        .bfree     (bfree),
        .irq       (irq),
        .err       (err),
        .irq_en    (irq_en),
        .crc_zero  (crc_zero),
        .host_rdata(host_rdata)
    );

    txh_blkbuf #(.DEPTH(DEPTH)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (buf_wr),
        .wr_byte(host_wdata),
        .clear  (done || soft_rst),
        .rd_ptr (rd_ptr),
        .count  (count),
        .rd_byte(push_byte)
    );

    txh_seq #(.DEPTH(DEPTH), .ROOM_W(ROOM_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_tx),
        .abort (soft_rst),
        .count (count),
        .room  (fifo_room),
        .push  (push_vld),
        .rd_ptr(rd_ptr),
        .done  (done)
    );

    // Active-low interrupt: pending flag gated by the enable bit.
    assign irq_n = !(irq && irq_en);
endmodule

// File: rtl/txh_chk.sv
// Protocol checker for txhand_ctrl, attached with bind below.
module txh_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr,
    input logic       rd,
    input logic [1:0] addr,
    input logic [2:0] task_code,
    input logic       bfree,
    input logic       irq,
    input logic       err,
    input logic       irq_en,
    input logic       irq_n,
    input logic       push_vld
);
    // R4
    push_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_vld |-> !bfree);

    // R3
    accept_clears_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 2'd1 && task_code != 3'b000 && task_code != 3'b111 && bfree)
        |=> !bfree);

    // R8
    reset_task_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 2'd1 && task_code == 3'b111) |=> (bfree && !irq));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R7
    stat_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == 2'd2 && bfree) |=> (!irq && bfree));

    // R6
    irq_pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_en) |-> !irq_n);

    // R6
    irq_pin_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> irq_n);

    // R5
    release_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bfree) && !$past(wr)) |-> irq);
endmodule

bind txhand_ctrl txh_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (host_wr),
    .rd       (host_rd),
    .addr     (host_addr),
    .task_code(host_wdata[2:0]),
    .bfree    (bfree),
    .irq      (irq),
    .err      (err),
    .irq_en   (irq_en),
    .irq_n    (irq_n),
    .push_vld (push_vld)
);

// File: tb/txhand_ctrl_tb.sv
`timescale 1ns/1ps
module txhand_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic [4:0] fifo_room = 5'd16;
    logic       push_vld;
    logic [7:0] push_byte;
    logic       crc_zero;
    logic       irq_n;

    int         checks = 0;
    int         errors = 0;
    bit         done_flag = 1'b0;
    logic [7:0] cap [256];
    int         cap_n = 0;

    // Each entry: writes[12:9], seed[8:1], crc select[0]; byte i = seed + 3*i.
    localparam logic [12:0] VECS [4] = '{
        {4'd1,  8'hA5, 1'b0},
        {4'd3,  8'h10, 1'b1},
        {4'd10, 8'hF0, 1'b0},
        {4'd5,  8'h33, 1'b1}
    };

    txhand_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .fifo_room(fifo_room), .push_vld(push_vld), .push_byte(push_byte),
        .crc_zero(crc_zero), .irq_n(irq_n)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        if (push_vld && cap_n < 256) begin
            cap[cap_n] = push_byte;
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #400000;
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            report();
        end
    end

    initial begin
        logic [7:0] s;
        int base;
        tick(4);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        chk("R1 irq_n", irq_n, 1);
        chk("R1 push", push_vld, 0);
        chk("R1 crc_zero", crc_zero, 0);
        rd(2'd2, s);
        chk("R1 status", s, 8'h01);

        wr(2'd3, 8'h01);

        // Table walk: R2 R4 R5 R6 R7 R10
        foreach (VECS[k]) begin
            int w;
            int n;
            int bad;
            logic [7:0] seed;
            w = int'(VECS[k][12:9]);
            seed = VECS[k][8:1];
            n = (w > 8) ? 8 : w;
            base = cap_n;
            for (int i = 0; i < w; i++) wr(2'd0, seed + 8'(3 * i));
            wr(2'd1, {2'b00, VECS[k][0], 5'b00001});
            tick(n + 4);
            chk("R4 push count", cap_n - base, n);
            bad = 0;
            for (int i = 0; i < n; i++)
                if (cap[base + i] != seed + 8'(3 * i)) bad++;
            chk("R2 byte order", bad, 0);
            chk("R10 crc_zero", crc_zero, int'(VECS[k][0]));
            chk("R6 irq_n low", irq_n, 0);
            rd(2'd2, s);
            chk("R5 status done", s, 8'h03);
            chk("R7 irq_n released", irq_n, 1);
            rd(2'd2, s);
            chk("R7 status after read", s, 8'h01);
        end

        // R5 empty block
        base = cap_n;
        wr(2'd1, 8'h01);
        tick(4);
        chk("R5 empty pushes", cap_n - base, 0);
        rd(2'd2, s);
        chk("R5 empty status", s, 8'h03);

        // R3 null task
        base = cap_n;
        wr(2'd0, 8'h5A);
        wr(2'd1, 8'h00);
        tick(4);
        rd(2'd2, s);
        chk("R3 null status", s, 8'h01);
        chk("R3 null pushes", cap_n - base, 0);
        wr(2'd1, 8'h07);

        // R4 stall and R9 ignored accesses
        fifo_room = 5'd2;
        base = cap_n;
        for (int i = 0; i < 4; i++) wr(2'd0, 8'h40 + 8'(i));
        wr(2'd1, 8'h01);
        tick(10);
        chk("R4 stalled pushes", cap_n - base, 0);
        rd(2'd2, s);
        chk("R3 busy status", s, 8'h00);
        wr(2'd0, 8'h77);
        wr(2'd1, 8'h21);
        rd(2'd2, s);
        chk("R9 err set", s, 8'h04);
        fifo_room = 5'd16;
        tick(8);
        chk("R9 push count unchanged", cap_n - base, 4);
        chk("R9 last byte", cap[base + 3], 8'h43);
        chk("R9 crc_zero unchanged", crc_zero, 0);
        rd(2'd2, s);
        chk("R9 status", s, 8'h07);

        // R8 reset task during stall
        fifo_room = 5'd0;
        base = cap_n;
        for (int i = 0; i < 3; i++) wr(2'd0, 8'h90 + 8'(i));
        wr(2'd1, 8'h01);
        tick(4);
        wr(2'd1, 8'h07);
        rd(2'd2, s);
        chk("R8 status", s, 8'h05);
        chk("R8 irq_n", irq_n, 1);
        fifo_room = 5'd16;
        tick(6);
        chk("R8 no pushes", cap_n - base, 0);
        wr(2'd0, 8'hC1);
        wr(2'd0, 8'hC2);
        wr(2'd1, 8'h01);
        tick(6);
        chk("R8 fresh count", cap_n - base, 2);
        chk("R8 fresh byte0", cap[base], 8'hC1);
        rd(2'd2, s);

        // R6 interrupts masked
        wr(2'd3, 8'h00);
        wr(2'd0, 8'h11);
        wr(2'd1, 8'h01);
        tick(5);
        chk("R6 masked irq_n", irq_n, 1);
        rd(2'd2, s);
        chk("R6 irq flag", s, 8'h07);

        // R9 only rst_n clears the error
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        rd(2'd2, s);
        chk("R9 cleared by rst_n", s, 8'h01);

        done_flag = 1'b1;
        report();
    end
endmodule